// File: doc/BRIEF.md
# Sliding-Window Streaming Median Engine

This block keeps the eight most recent 32-bit unsigned samples of a stream and, for every sample written, produces the median of that window. The median of an even-sized window is the mean of its two middle elements, rounded down. A one-cycle write strobe pushes a sample into a linear shift register, and the oldest sample falls out of the far end. The eight window registers feed a compare-exchange network that is pruned so that it only isolates the two middle ranks. An adder then averages those two values, taking the top bits of its carry-extended sum.

A parameter picks one of two builds. The combinational build evaluates the whole network in one long path and captures the result a fixed number of cycles (two or three) after the write. Writes must then be spaced at least that many cycles apart. The pipelined build registers every network stage, accepts a write on every cycle, and returns each result a fixed six cycles after its write. In both builds, a one-cycle valid pulse marks each result whose window was completely filled with real samples. A level flag reports that the window has filled since reset.

Top module: `median_window_engine`

## Requirements
- R1: Each cycle with `sample_wr` high shifts `sample_in` into the window as its newest element and discards the oldest of the eight; cycles without the strobe leave the window unchanged.
- R2: The result equals floor((a + b) / 2), where a and b are the 4th and 5th smallest of the eight window values, computed without overflow (eight samples of 0xFFFFFFFF give 0xFFFFFFFF).
- R3: `window_full` is 0 from reset until the eighth write has taken effect (one cycle after the edge that samples it) and stays 1 afterwards.
- R4: `median_valid` is high for exactly one cycle per write whose shift leaves the window full, and is never high otherwise.
- R5: In the pipelined build, writes may arrive on consecutive cycles, and each result appears on `median_out` with `median_valid` in the cycle following the 6th clock edge after the edge that samples the write.
- R6: In the combinational build with settle parameter W (2 or 3, default 2), the result appears in the cycle following the W-th edge after the write edge, and successive writes must be at least W cycles apart.
- R7: After reset, `median_out` is 0, `median_valid` is 0, `window_full` is 0, and all eight window elements are 0, so a result taken before the window is full counts the missing samples as zeros (four writes of 1000 give 500).
- R8: `median_out` is updated once for every write, including writes before the window is full, and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_wr | input | 1 | Write strobe; shifts `sample_in` into the window |
| sample_in | input | 32 | Unsigned sample value |
| median_out | output | 32 | Median of the window as it stood after the write |
| median_valid | output | 1 | One-cycle pulse for a result taken from a full window |
| window_full | output | 1 | Window has received eight samples since reset |

## Verification
In the pipelined build, a new write can be accepted in the same cycle that an earlier write's result leaves the output register. Five older samples can also be in flight through the network stages at that moment. Bursts of back-to-back writes with random gaps provoke this overlap. Every output is judged against a reference window that the bench keeps itself: each result must carry the sort-and-average value of its own window and arrive at exactly the expected cycle, with the valid flag set only when that window was full. In the combinational build, the overlap is a write landing on the same edge as the capture of the previous result. The bench provokes this with writes spaced exactly at the settle distance and checks that the captured value is the older window's.

// File: rtl/median_pkg.sv
package median_pkg;

   // Fixed geometry of the window and of the pruned network.
   localparam int MW_LANES   = 8;
   localparam int MW_STAGES  = 5;
   localparam int MW_MID_LO  = 3;
   localparam int MW_MID_HI  = 4;

   typedef enum logic {
      MW_BUILD_COMB = 1'b0,
      MW_BUILD_PIPE = 1'b1
   } mw_build_e;

   // Lane that lane i meets in stage s; returns i when the lane passes through.
   // The larger value always goes to the higher lane index. The final
   // ordering stage of a full merge sorter is dropped: the averaging adder is
   // symmetric, so the two middle lanes need not be ordered between themselves.
   function automatic int mw_partner(input int s, input int i);
      case (s)
         0:       return i ^ 1;
         1:       return i ^ 2;
         2:       return ((i % 4) == 1) ? i + 1 : ((i % 4) == 2) ? i - 1 : i;
         3:       return i ^ 4;
         default: return (i == 2 || i == 3) ? i + 2 :
                         (i == 4 || i == 5) ? i - 2 : i;
      endcase
   endfunction

endpackage

// File: rtl/mw_window.sv
module mw_window #(
   parameter int DATA_W = 32
) (
   input  logic                                           clk,
   input  logic                                           rst_n,
   input  logic                                           shift_en,
   input  logic [DATA_W-1:0]                              din,
   output logic [median_pkg::MW_LANES-1:0][DATA_W-1:0]    win,
   output logic                                           full,
   output logic                                           last_slot
);
   localparam int LANES  = median_pkg::MW_LANES;
   localparam int FILL_W = $clog2(LANES + 1);

   logic [FILL_W-1:0] fill_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win <= '0;
      end else if (shift_en) begin
         win <= {win[LANES-2:0], din};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill_q <= '0;
      end else if (shift_en && (fill_q != FILL_W'(LANES))) begin
         fill_q <= fill_q + 1'b1;
      end
   end

   assign full      = (fill_q == FILL_W'(LANES));
   assign last_slot = (fill_q == FILL_W'(LANES - 1));

   // R1: the newest slot takes the sample, the rest move up one place.
   p_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> (win[0] == $past(din)) && (win[1] == $past(win[0])));

   // R1: no strobe, no movement.
   p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(win));

   // R3: the fill count never passes the window depth.
   p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q <= FILL_W'(LANES));

endmodule

// File: rtl/mw_cmpx.sv
module mw_cmpx #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] lo,
   output logic [DATA_W-1:0] hi
);
   logic a_ge_b;

   always_comb begin
      a_ge_b = (a >= b);
      lo     = a_ge_b ? b : a;
      hi     = a_ge_b ? a : b;
   end

endmodule

// File: rtl/mw_sortnet.sv
module mw_sortnet #(
   parameter int                    DATA_W = 32,
   parameter median_pkg::mw_build_e BUILD  = median_pkg::MW_BUILD_PIPE
) (
   input  logic                                        clk,
   input  logic [median_pkg::MW_LANES-1:0][DATA_W-1:0] row_in,
   output logic [DATA_W-1:0]                           mid_a,
   output logic [DATA_W-1:0]                           mid_b
);
   localparam int LANES  = median_pkg::MW_LANES;
   localparam int STAGES = median_pkg::MW_STAGES;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [LANES-1:0][DATA_W-1:0] st_in;
      logic [LANES-1:0][DATA_W-1:0] st_cx;
      logic [LANES-1:0][DATA_W-1:0] st_out;

      if (s == 0) begin : g_first
         assign st_in = row_in;
      end else begin : g_chain
         assign st_in = g_stage[s-1].st_out;
      end

      for (genvar i = 0; i < LANES; i++) begin : g_lane
         localparam int P = median_pkg::mw_partner(s, i);
         if (P > i) begin : g_cell
            mw_cmpx #(.DATA_W(DATA_W)) u_cx (
               .a  (st_in[i]),
               .b  (st_in[P]),
               .lo (st_cx[i]),
               .hi (st_cx[P])
            );
         end else if (P == i) begin : g_pass
            assign st_cx[i] = st_in[i];
         end
      end

      if (BUILD == median_pkg::MW_BUILD_PIPE) begin : g_reg
         always_ff @(posedge clk) begin
            st_out <= st_cx;
         end
      end else begin : g_wire
         assign st_out = st_cx;
      end
   end

   assign mid_a = g_stage[STAGES-1].st_out[median_pkg::MW_MID_LO];
   assign mid_b = g_stage[STAGES-1].st_out[median_pkg::MW_MID_HI];

endmodule

// File: rtl/mw_midavg.sv
module mw_midavg #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] avg
);
   localparam int SUM_W = DATA_W + 1;

   logic [SUM_W-1:0] sum;

   // The halving is a wiring choice: the top DATA_W bits of the sum.
   always_comb begin
      sum = {1'b0, a} + {1'b0, b};
      avg = sum[SUM_W-1:1];
   end

endmodule

// File: rtl/median_window_engine.sv
module median_window_engine #(
   parameter int                    DATA_W     = 32,
   parameter median_pkg::mw_build_e BUILD      = median_pkg::MW_BUILD_PIPE,
   parameter int                    SETTLE_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_wr,
   input  logic [DATA_W-1:0] sample_in,
   output logic [DATA_W-1:0] median_out,
   output logic              median_valid,
   output logic              window_full
);
   localparam int LANES  = median_pkg::MW_LANES;
   localparam int STAGES = median_pkg::MW_STAGES;
   localparam bit IS_PIPE = (BUILD == median_pkg::MW_BUILD_PIPE);
   // Edges from the write edge to the edge that loads the output register.
   localparam int LAT    = IS_PIPE ? STAGES + 1 : SETTLE_CYC;
   localparam int GAP_W  = $clog2(SETTLE_CYC + 1);

   if (DATA_W < 1) begin : g_bad_width
      $error("median_window_engine: DATA_W must be at least 1");
   end
   if (!IS_PIPE && (SETTLE_CYC < 2 || SETTLE_CYC > 3)) begin : g_bad_settle
      $error("median_window_engine: SETTLE_CYC must be 2 or 3");
   end

   logic [LANES-1:0][DATA_W-1:0] win;
   logic                         last_slot;
   logic [DATA_W-1:0]            mid_a;
   logic [DATA_W-1:0]            mid_b;
   logic [DATA_W-1:0]            avg;
   logic [LAT-1:0]               tag_q;
   logic [LAT-1:0]               full_tag_q;
   logic                         load_now;

   mw_window #(.DATA_W(DATA_W)) u_window (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_en  (sample_wr),
      .din       (sample_in),
      .win       (win),
      .full      (window_full),
      .last_slot (last_slot)
   );

   mw_sortnet #(.DATA_W(DATA_W), .BUILD(BUILD)) u_net (
      .clk    (clk),
      .row_in (win),
      .mid_a  (mid_a),
      .mid_b  (mid_b)
   );

   mw_midavg #(.DATA_W(DATA_W)) u_avg (
      .a   (mid_a),
      .b   (mid_b),
      .avg (avg)
   );

   // Tags travel alongside the data: one per write, plus whether that write
   // left the window full.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tag_q      <= '0;
         full_tag_q <= '0;
      end else begin
         tag_q      <= {tag_q[LAT-2:0], sample_wr};
         full_tag_q <= {full_tag_q[LAT-2:0],
                        sample_wr && (window_full || last_slot)};
      end
   end

   assign load_now = tag_q[LAT-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         median_out   <= '0;
         median_valid <= 1'b0;
      end else begin
         median_valid <= load_now && full_tag_q[LAT-1];
         if (load_now) begin
            median_out <= avg;
         end
      end
   end

   if (!IS_PIPE) begin : g_spacing
      logic [GAP_W-1:0] gap_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            gap_q <= GAP_W'(SETTLE_CYC);
         end else if (sample_wr) begin
            gap_q <= '0;
         end else if (gap_q != GAP_W'(SETTLE_CYC)) begin
            gap_q <= gap_q + 1'b1;
         end
      end

      // R6: a write may not disturb the window while an earlier one settles.
      p_write_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
         sample_wr |-> (gap_q >= GAP_W'(SETTLE_CYC - 1)));

      // R4: with spaced writes the valid flag never lasts two cycles.
      p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
         median_valid |=> !median_valid);
   end

   // R4: a valid result implies the window had filled.
   p_valid_needs_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      median_valid |-> window_full);

   // R3: once full, the window stays full.
   p_full_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      window_full |=> window_full);

   // R8: the output only moves when a tagged result arrives.
   p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !load_now |=> $stable(median_out));

endmodule

// File: tb/median_window_engine_bench.sv
module median_window_engine_bench;

   localparam int LAT_P = 6;
   localparam int LAT_C = 2;
   localparam int RB    = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_p = 1'b0, wr_c = 1'b0;
   logic [31:0] din_p = '0, din_c = '0;
   logic [31:0] out_p, out_c;
   logic        val_p, val_c, full_p, full_c;

   int vectors = 0;
   int fails   = 0;
   int ncnt    = 0;
   int cyc     = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   median_window_engine #(
      .DATA_W(32), .BUILD(median_pkg::MW_BUILD_PIPE), .SETTLE_CYC(2)
   ) u_median_window_engine (
      .clk(clk), .rst_n(rst_n), .sample_wr(wr_p), .sample_in(din_p),
      .median_out(out_p), .median_valid(val_p), .window_full(full_p)
   );

   median_window_engine #(
      .DATA_W(32), .BUILD(median_pkg::MW_BUILD_COMB), .SETTLE_CYC(LAT_C)
   ) u_median_window_engine_comb (
      .clk(clk), .rst_n(rst_n), .sample_wr(wr_c), .sample_in(din_c),
      .median_out(out_c), .median_valid(val_c), .window_full(full_c)
   );

   // Reference model state, index 0 = pipelined, 1 = combinational.
   logic [31:0] mwin   [2][8];
   int          fill   [2];
   logic [31:0] exp_v  [2][RB];
   bit          exp_f  [2][RB];
   int          exp_d  [2][RB];
   int          head   [2];
   int          tail   [2];
   logic [31:0] last_o [2];

   function automatic logic [31:0] ref_median(input logic [31:0] w [8]);
      logic [31:0] s [8];
      logic [31:0] t;
      logic [32:0] sum;
      for (int i = 0; i < 8; i++) s[i] = w[i];
      for (int i = 0; i < 8; i++)
         for (int j = 0; j < 7 - i; j++)
            if (s[j] > s[j+1]) begin t = s[j]; s[j] = s[j+1]; s[j+1] = t; end
      sum = {1'b0, s[3]} + {1'b0, s[4]};
      return sum[32:1];
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, ncnt);
      end
   endtask

   initial begin
      for (int d = 0; d < 2; d++) begin
         fill[d] = 0; head[d] = 0; tail[d] = 0; last_o[d] = '0;
         for (int i = 0; i < 8; i++) mwin[d][i] = '0;
      end
   end

   // Monitor: samples at the falling edge, away from the active edge.
   always @(negedge clk) begin
      if (rst_n) begin
         ncnt++;
         for (int d = 0; d < 2; d++) begin
            logic        w, v, f;
            logic [31:0] o, din;
            logic [31:0] tmp [8];
            int          lat;
            w   = d ? wr_c  : wr_p;
            v   = d ? val_c : val_p;
            f   = d ? full_c : full_p;
            o   = d ? out_c : out_p;
            din = d ? din_c : din_p;
            lat = d ? LAT_C : LAT_P;

            if (head[d] != tail[d] && exp_d[d][head[d] % RB] == ncnt) begin
               // R2 value plus R5/R6 latency: the result lands exactly now.
               check(o == exp_v[d][head[d] % RB], d ? "R2/R6 value" : "R2/R5 value",
                     o, exp_v[d][head[d] % RB]);
               // R4: valid set only for a full window.
               check(v == exp_f[d][head[d] % RB], "R4 valid flag",
                     32'(v), 32'(exp_f[d][head[d] % RB]));
               last_o[d] = exp_v[d][head[d] % RB];
               head[d]++;
            end else begin
               // R4: no valid without a due result.
               check(!v, "R4 stray valid", 32'(v), 32'd0);
               // R8: output holds between results.
               check(o == last_o[d], "R8 hold", o, last_o[d]);
            end

            if (w) begin
               // R3: the flag reflects the writes already taken.
               check(f == (fill[d] >= 8), "R3 full flag", 32'(f), 32'(fill[d] >= 8));
               // R1: model shift, newest at slot 0.
               for (int i = 7; i > 0; i--) mwin[d][i] = mwin[d][i-1];
               mwin[d][0] = din;
               if (fill[d] < 8) fill[d]++;
               for (int i = 0; i < 8; i++) tmp[i] = mwin[d][i];
               exp_v[d][tail[d] % RB] = ref_median(tmp);
               exp_f[d][tail[d] % RB] = (fill[d] == 8);
               exp_d[d][tail[d] % RB] = ncnt + lat + 1;
               tail[d]++;
            end
         end
      end
   end

   function automatic logic [31:0] pattern(input int i);
      if (i < 4)       return 32'd1000;                       // R7: partial window
      else if (i < 16) return 32'hFFFF_FFFF;                  // R2: sum overflow
      else if (i < 24) return (i % 2) ? 32'hFFFF_FFFF : 32'd0;
      else if (i < 40) return 32'(100 - (i - 24));            // R1: oldest drops
      else if (i < 56) return 32'(7 + (i - 40));
      else if (i < 64) return 32'd42;                         // duplicates
      else if (i % 3 == 0) return $urandom & 32'h7;
      else return $urandom;
   endfunction

   task automatic step_p(input bit w, input logic [31:0] v);
      @(posedge clk); #1; wr_p = w; din_p = v;
   endtask

   task automatic step_c(input bit w, input logic [31:0] v);
      @(posedge clk); #1; wr_c = w; din_c = v;
   endtask

   task automatic run_pipe();
      for (int i = 0; i < 360; i++) begin
         step_p(1'b1, pattern(i));                            // R5: back-to-back
         if (i >= 64 && ($urandom % 4) == 0)
            for (int k = 0; k < int'($urandom % 3) + 1; k++) step_p(1'b0, '0);
      end
      step_p(1'b0, '0);
   endtask

   task automatic run_comb();
      for (int i = 0; i < 360; i++) begin
         step_c(1'b1, pattern(i));
         // R6: spacing exactly at the settle distance, sometimes longer.
         for (int k = 0; k < ((i < 64) ? LAT_C - 1 : int'($urandom % 3) + LAT_C - 1); k++)
            step_c(1'b0, '0);
      end
      step_c(1'b0, '0);
   endtask

   initial begin : watchdog
      while (cyc < 100000 && !done) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         fails++;
         vectors++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd20240611));
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R7: reset state on both builds.
      check(out_p == 0 && out_c == 0, "R7 reset output", out_p | out_c, 32'd0);
      check(!val_p && !val_c, "R7 reset valid", 32'(val_p | val_c), 32'd0);
      check(!full_p && !full_c, "R7 reset full", 32'(full_p | full_c), 32'd0);
      fork
         run_pipe();
         run_comb();
      join
      repeat (20) @(posedge clk);
      @(negedge clk);
      for (int d = 0; d < 2; d++)
         check(head[d] == tail[d], "R8 result count", 32'(tail[d] - head[d]), 32'd0);
      // R3: a full window after many writes.
      check(full_p && full_c, "R3 full at end", 32'(full_p & full_c), 32'd1);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule